// File: doc/BRIEF.md
# Event-Triggered Self-Test Pulse Sequencer

This block drives the self-test enable lines of a group of detector front ends. While the test function is switched on, it watches the stream of machine timing events. When an event whose number equals the programmed test event number arrives, the block counts out a programmable delay in milliseconds. It then raises the test level for a programmable number of milliseconds and drops it again. A per-channel mask selects which channel outputs follow the level. An all-ones mask drives every channel at the same time.

Test pulses and range switching must never overlap. The block takes a busy input from the range-setting logic. If that input is high when the delay runs out, the test for that cycle is not started. If it rises while a pulse is running, the pulse ends at once. In both cases a sticky flag records that a test was lost, and the host clears the flag with a one-cycle strobe. Millisecond timing comes from a prescaler of `CLK_PER_MS` clock cycles. The prescaler restarts whenever a timer is loaded, so every delay and duration is an exact multiple of the millisecond period.

Top module: `stp_seq`

## Requirements
- R1: After reset, `test_o`, `test_level_o`, `busy_o` and `skipped_o` are all 0.
- R2: A sequence starts only when `test_en_i` is 1, `evt_valid_i` is 1 and `evt_num_i` equals `evt_cfg_i`. Any other event leaves `busy_o` and `test_level_o` at 0.
- R3: If the accepting event is sampled at edge k, `test_level_o` rises at edge k+L, with L = `delay_ms_i`*`CLK_PER_MS`, or L = 1 when the delay is 0.
- R4: `test_level_o` stays high for exactly `dur_ms_i`*`CLK_PER_MS` cycles. A duration of 0 produces no pulse and sets no flag.
- R5: If `range_busy_i` is 1 in the cycle the delay expires, no pulse is produced and `skipped_o` is set.
- R6: If `range_busy_i` is 1 while `test_level_o` is high, the level is 0 after the next edge and `skipped_o` is set.
- R7: If `test_en_i` is 0 while `test_level_o` is high, the level is 0 after the next edge. Clearing the enable during the delay cancels the pulse.
- R8: `skipped_o` holds its value until `skip_clr_i` is sampled high. A new set in the same cycle wins over the clear.
- R9: `test_o[i]` equals `test_level_o & chan_mask_i[i]` for every channel i.
- R10: After a pulse ends, the block spends exactly one cycle in a done state before it returns to idle. `busy_o` is 1 from the accepting edge until that return. Events that arrive while `busy_o` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Self-test function on/off |
| evt_cfg_i | input | EVW | Programmed trigger event number |
| delay_ms_i | input | MSW | Delay from event to pulse, in ms |
| dur_ms_i | input | MSW | Pulse duration, in ms |
| chan_mask_i | input | NCH | Channels that follow the test level |
| evt_valid_i | input | 1 | Timing event strobe |
| evt_num_i | input | EVW | Number of the current timing event |
| range_busy_i | input | 1 | Range update in progress |
| skip_clr_i | input | 1 | Clears the skipped flag |
| test_o | output | NCH | Per-channel test enables |
| test_level_o | output | 1 | Unmasked test level |
| busy_o | output | 1 | Sequence in progress |
| skipped_o | output | 1 | Sticky flag: a test was skipped or aborted |

## Verification
A sequencer stuck outside idle shows within one event as `busy_o` held high and as a trigger that does nothing. A prescaler or timer that is off by one shows as a rising edge or a pulse width that differs from a whole number of milliseconds, and this appears on the first pulse. A broken interlock shows on the first cycle that `range_busy_i` overlaps the pulse, either as the level staying high or as `skipped_o` staying low. Mask faults appear at the rising edge, when `test_o` is compared with the programmed mask.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DONE   = 2'd3
  } stp_state_e;
endpackage

// File: rtl/stp_ms_tick.sv
module stp_ms_tick #(
  parameter int unsigned CLK_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (clr_i)       pre_q <= '0;
    else if (tick_o)      pre_q <= '0;
    else if (run_i)       pre_q <= pre_q + 1'b1;
  end

  // R3/R4: the prescaler never passes one millisecond
  p_pre_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
endmodule

// File: rtl/stp_ms_timer.sv
module stp_ms_timer #(
  parameter int unsigned MSW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_i,
  input  logic [MSW-1:0] ld_val_i,
  input  logic           tick_i,
  output logic           zero_o,
  output logic           one_o
);
  logic [MSW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == MSW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (ld_i)              cnt_q <= ld_val_i;
    else if (tick_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  // R4: a tick without a load moves the count down by exactly one
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/stp_seq.sv
module stp_seq
  import stp_pkg::*;
#(
  parameter int unsigned NCH        = 8,
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned EVW        = 16,
  parameter int unsigned MSW        = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           test_en_i,
  input  logic [EVW-1:0] evt_cfg_i,
  input  logic [MSW-1:0] delay_ms_i,
  input  logic [MSW-1:0] dur_ms_i,
  input  logic [NCH-1:0] chan_mask_i,
  input  logic           evt_valid_i,
  input  logic [EVW-1:0] evt_num_i,
  input  logic           range_busy_i,
  input  logic           skip_clr_i,
  output logic [NCH-1:0] test_o,
  output logic           test_level_o,
  output logic           busy_o,
  output logic           skipped_o
);
  stp_state_e     state_q, state_d;
  logic           tick, ld, cnt_zero, cnt_one, expire, skip_set, run;
  logic [MSW-1:0] ld_val;
  logic           skipped_q;

  assign run    = (state_q == ST_DELAY) || (state_q == ST_ACTIVE);
  assign expire = cnt_zero || (tick && cnt_one);

  stp_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (ld),
    .tick_o (tick)
  );

  stp_ms_timer #(.MSW(MSW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .tick_i   (tick),
    .zero_o   (cnt_zero),
    .one_o    (cnt_one)
  );

  always_comb begin
    state_d  = state_q;
    ld       = 1'b0;
    ld_val   = delay_ms_i;
    skip_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (test_en_i && evt_valid_i && (evt_num_i == evt_cfg_i)) begin
          state_d = ST_DELAY;
          ld      = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!test_en_i) begin
          state_d = ST_DONE;
        end else if (expire) begin
          if (range_busy_i) begin
            skip_set = 1'b1;
            state_d  = ST_DONE;
          end else if (dur_ms_i == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ACTIVE;
            ld      = 1'b1;
            ld_val  = dur_ms_i;
          end
        end
      end
      ST_ACTIVE: begin
        if (!test_en_i) begin
          state_d = ST_DONE;
        end else if (range_busy_i) begin
          skip_set = 1'b1;
          state_d  = ST_DONE;
        end else if (expire) begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      skipped_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (skip_set)        skipped_q <= 1'b1;
      else if (skip_clr_i) skipped_q <= 1'b0;
    end
  end

  assign test_level_o = (state_q == ST_ACTIVE);
  assign busy_o       = (state_q != ST_IDLE);
  assign skipped_o    = skipped_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign test_o[g] = test_level_o & chan_mask_i[g];
  end

  p_busy_ends_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_level_o && range_busy_i) |=> (!test_level_o && skipped_o));

  p_enable_ends_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_level_o && !test_en_i) |=> !test_level_o);

  p_done_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  p_pulse_from_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_level_o) |-> ($past(state_q) == ST_DELAY));

  p_skip_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skipped_o && !skip_clr_i) |=> skipped_o);

  p_mask_respected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_o & ~chan_mask_i) == '0);
endmodule

// File: tb/stp_seq_tb_top.sv
module stp_seq_tb_top;
  localparam int NCH = 4;
  localparam int P   = 4;
  localparam int LIM = 2000;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           test_en_i = 1'b0;
  logic [15:0]    evt_cfg_i = 16'd55;
  logic [15:0]    delay_ms_i = '0;
  logic [15:0]    dur_ms_i = '0;
  logic [NCH-1:0] chan_mask_i = '1;
  logic           evt_valid_i = 1'b0;
  logic [15:0]    evt_num_i = '0;
  logic           range_busy_i = 1'b0;
  logic           skip_clr_i = 1'b0;
  logic [NCH-1:0] test_o;
  logic           test_level_o, busy_o, skipped_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  stp_seq #(.NCH(NCH), .CLK_PER_MS(P), .EVW(16), .MSW(16)) dut_i (
    .clk_i, .rst_ni, .test_en_i, .evt_cfg_i, .delay_ms_i, .dur_ms_i,
    .chan_mask_i, .evt_valid_i, .evt_num_i, .range_busy_i, .skip_clr_i,
    .test_o, .test_level_o, .busy_o, .skipped_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one event for one cycle; returns after the accepting edge
  task automatic fire(input logic [15:0] num);
    @(negedge clk_i);
    evt_num_i   = num;
    evt_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  // cycles from event edge to rise; first negedge after the event edge is 1
  task automatic wait_rise(output int rise);
    int c = 1;
    while (!test_level_o && c < LIM) begin
      @(negedge clk_i);
      c++;
    end
    rise = c;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < LIM && busy_o; i++) @(negedge clk_i);
  endtask

  // delay, duration, mask
  typedef struct packed {
    logic [15:0] d;
    logic [15:0] w;
    logic [3:0]  m;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{16'd2, 16'd3, 4'hF},
    '{16'd0, 16'd1, 4'h5},
    '{16'd1, 16'd2, 4'hA},
    '{16'd3, 16'd1, 4'h1}
  };

  initial begin : wd
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int rise, wid, seen;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 test_o", int'(test_o), 0);
    chk("R1 level", int'(test_level_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 skipped", int'(skipped_o), 0);
    rst_ni = 1'b1;
    test_en_i = 1'b1;
    @(negedge clk_i);

    // R3 R4 R9 table walk
    foreach (VEC[i]) begin
      delay_ms_i  = VEC[i].d;
      dur_ms_i    = VEC[i].w;
      chan_mask_i = VEC[i].m;
      fire(16'd55);
      wait_rise(rise);
      chk("R3 rise cycle", rise - 1, (VEC[i].d == 0) ? 1 : int'(VEC[i].d) * P);
      chk("R9 mask", int'(test_o), int'(VEC[i].m));
      wid = 1;
      @(negedge clk_i);
      while (test_level_o && wid < LIM) begin
        wid++;
        @(negedge clk_i);
      end
      chk("R4 width", wid, int'(VEC[i].w) * P);
      // R10: one done cycle, then idle
      chk("R10 busy in done", int'(busy_o), 1);
      @(negedge clk_i);
      chk("R10 idle after done", int'(busy_o), 0);
      chk("R5 no skip", int'(skipped_o), 0);
    end
    chan_mask_i = '1;

    // R2 wrong number and disabled
    delay_ms_i = 16'd0; dur_ms_i = 16'd1;
    fire(16'd54);
    repeat (4) @(negedge clk_i);
    chk("R2 wrong event busy", int'(busy_o), 0);
    test_en_i = 1'b0;
    fire(16'd55);
    repeat (4) @(negedge clk_i);
    chk("R2 disabled busy", int'(busy_o) | int'(test_level_o), 0);
    test_en_i = 1'b1;

    // R4 zero duration
    delay_ms_i = 16'd1; dur_ms_i = 16'd0;
    fire(16'd55);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (test_level_o) seen = 1;
      @(negedge clk_i);
    end
    chk("R4 zero dur pulse", seen, 0);
    chk("R4 zero dur flag", int'(skipped_o), 0);
    chk("R4 zero dur idle", int'(busy_o), 0);

    // R5 busy at expiry, R8 sticky and clear
    dur_ms_i = 16'd2;
    range_busy_i = 1'b1;
    fire(16'd55);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (test_level_o) seen = 1;
      @(negedge clk_i);
    end
    range_busy_i = 1'b0;
    chk("R5 skipped pulse", seen, 0);
    chk("R5 flag set", int'(skipped_o), 1);
    repeat (5) @(negedge clk_i);
    chk("R8 flag sticky", int'(skipped_o), 1);
    skip_clr_i = 1'b1;
    @(negedge clk_i);
    skip_clr_i = 1'b0;
    chk("R8 flag cleared", int'(skipped_o), 0);

    // R6 busy during active
    delay_ms_i = 16'd0; dur_ms_i = 16'd5;
    fire(16'd55);
    wait_rise(rise);
    @(negedge clk_i);
    range_busy_i = 1'b1;
    @(negedge clk_i);
    chk("R6 pulse ended", int'(test_level_o), 0);
    chk("R6 flag set", int'(skipped_o), 1);
    range_busy_i = 1'b0;
    wait_idle();
    skip_clr_i = 1'b1;
    @(negedge clk_i);
    skip_clr_i = 1'b0;

    // R7 enable dropped during active
    fire(16'd55);
    wait_rise(rise);
    @(negedge clk_i);
    test_en_i = 1'b0;
    @(negedge clk_i);
    chk("R7 pulse ended", int'(test_level_o), 0);
    test_en_i = 1'b1;
    wait_idle();

    // R7 enable dropped during delay
    delay_ms_i = 16'd3;
    fire(16'd55);
    @(negedge clk_i);
    test_en_i = 1'b0;
    @(negedge clk_i);
    test_en_i = 1'b1;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (test_level_o) seen = 1;
      @(negedge clk_i);
    end
    chk("R7 cancel in delay", seen, 0);
    chk("R7 no flag", int'(skipped_o), 0);

    // R10 events ignored while busy
    delay_ms_i = 16'd0; dur_ms_i = 16'd2;
    fire(16'd55);
    wait_rise(rise);
    fire(16'd55);
    wait_idle();
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (test_level_o || busy_o) seen = 1;
      @(negedge clk_i);
    end
    chk("R10 retrigger ignored", seen, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule